// File: doc/BRIEF.md
# PCI Configuration and Memory Cycle Initiator

This block lets a local processor reach devices on a PCI bus through a plain request/acknowledge register port. Each local access becomes one single-data-phase PCI transaction. A mode input chooses the transaction type. When it is high, every access is issued as a configuration read or write. When it is low, every access is issued as a memory read or write. The mode is captured when the request is accepted.

The sequencer requests the bus and waits for the grant. It then drives the address alone on AD for a fixed number of clocks, so that logic outside the block can decode it and select the target's IDSEL line. After that it asserts FRAME with the command for one clock, and then asserts IRDY with the byte enables. It waits for the target to claim the data phase and finish it, retry it, or not answer at all. The outcome, and for reads the data, goes back to the local port with a one-cycle acknowledge.

Local accesses use big-endian halfword numbering. The halfword lane is therefore the inverse of the little-endian choice. A local halfword at offset 6 lands in PCI lanes 0-1, and one at offset 4 lands in lanes 2-3.

Top module: `pci_cfg_initiator`

## Requirements
- R1: After a local request is accepted in the idle state, req_n goes low on the next cycle. While gnt_n is high, the block keeps ad_oe and cbe_oe low and frame_n and irdy_n high. On the clock after gnt_n is sampled low, req_n returns high and ad_oe rises, with the local address (bits 1:0 cleared) on ad_o.
- R2: The address alone is held on ad_o for exactly STEP_CLKS (default 4) cycles with frame_n high before frame_n goes low.
- R3: While frame_n is low, cbe_oe is high and cbe_n_o carries the command. With configuration mode: read 4'hA, write 4'hB. Without it: read 4'h6, write 4'h7. The mode is taken from cfg_mode in the cycle the request is accepted.
- R4: frame_n is low for exactly one cycle. In the next cycle frame_n is high and irdy_n is low. For a write, ad_o carries the write data; for a read, ad_oe is low.
- R5: The data phase completes on the edge where devsel_n and trdy_n are both sampled low. loc_ack pulses high for one cycle after that edge, with loc_err and loc_retry low. For a read, loc_rdata holds the value captured from ad_i on that edge. While trdy_n stays high and stop_n stays high, no acknowledge is given.
- R6: If stop_n is sampled low without trdy_n, the transaction ends with loc_ack and loc_retry high and loc_err low. The block does not reissue it: req_n stays high afterwards.
- R7: If devsel_n is not sampled low on any of the first DEVSEL_WAIT (default 5) edges of the data phase, the transaction ends on that last edge. loc_ack and loc_err go high and loc_rdata is all ones.
- R8: In the acknowledge cycle the bus is released: irdy_n and frame_n are high, and ad_oe and cbe_oe are low.
- R9: A halfword access (loc_word=0) with local address bit 1 set uses PCI lanes 0-1: cbe_n_o is 4'b1100 in the data phase and write data goes on ad_o[15:0]. With bit 1 clear it uses lanes 2-3: cbe_n_o is 4'b0011 and write data goes on ad_o[31:16]. Unused lanes are zero. A halfword read returns the selected lanes zero-extended in loc_rdata[15:0].
- R10: A word access (loc_word=1) drives cbe_n_o 4'b0000 in the data phase, puts all 32 bits of write data on ad_o unchanged, and returns all 32 bits of ad_i on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | 1: configuration commands, 0: memory commands |
| loc_req | input | 1 | Local request, held until loc_ack |
| loc_we | input | 1 | 1: write, 0: read |
| loc_word | input | 1 | 1: 32-bit access, 0: halfword |
| loc_addr | input | ADDR_W | Local byte address |
| loc_wdata | input | 32 | Write data (halfword in bits 15:0) |
| loc_ack | output | 1 | One-cycle completion pulse |
| loc_err | output | 1 | Master abort, valid with loc_ack |
| loc_retry | output | 1 | Target stop without data, valid with loc_ack |
| loc_rdata | output | 32 | Read data, valid with loc_ack |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | FRAME, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| ad_o | output | 32 | Address/data out |
| ad_oe | output | 1 | AD output enable |
| ad_i | input | 32 | Address/data in |
| cbe_n_o | output | 4 | Command / byte enables out |
| cbe_oe | output | 1 | C/BE output enable |

## Verification
A wrong state register or stepping count shows at the bus pins within one clock. frame_n falls a cycle early or late relative to the first driven address, or irdy_n fails to follow frame_n on the next clock. A wrong outcome decode shows only in the acknowledge cycle, where the error and retry flags and the returned data are compared with what the bench told the target to do. A wrong lane choice shows in the data phase as wrong byte enables or misplaced write data, and at completion as the wrong half of the read value.

// File: rtl/pcim_pkg.sv
package pcim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_STEP,
        ST_FRAME,
        ST_DATA,
        ST_DONE
    } seq_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned BE_W  = BUS_W / 8;

endpackage

// File: rtl/pcim_lane.sv
module pcim_lane
    import pcim_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [BUS_W-1:0]  bus_addr,
    output logic [BE_W-1:0]   be_n,
    output logic [BUS_W-1:0]  lane_wdata,
    output logic [BUS_W-1:0]  rd_value
);
    localparam int unsigned HALF_W = BUS_W / 2;

    logic upper_half;

    // big-endian halfword numbering: bit 1 of the local address is inverted
    assign upper_half = ~addr[1];

    generate
        if (ADDR_W >= BUS_W) begin : g_wide
            assign bus_addr = {addr[BUS_W-1:2], 2'b00};
        end else begin : g_narrow
            assign bus_addr = {{(BUS_W-ADDR_W){1'b0}}, addr[ADDR_W-1:2], 2'b00};
        end
    endgenerate

    always_comb begin
        if (word) begin
            be_n       = '0;
            lane_wdata = wdata;
            rd_value   = ad_in;
        end else if (upper_half) begin
            be_n       = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
            lane_wdata = {wdata[HALF_W-1:0], {HALF_W{1'b0}}};
            rd_value   = {{HALF_W{1'b0}}, ad_in[BUS_W-1:HALF_W]};
        end else begin
            be_n       = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
            lane_wdata = {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
            rd_value   = {{HALF_W{1'b0}}, ad_in[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/pcim_wait.sv
module pcim_wait #(
    parameter int unsigned DEVSEL_WAIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic devsel_n,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(DEVSEL_WAIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEVSEL_WAIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
    } wait_t;

    wait_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (!run) begin
            w_d.cnt  = '0;
            w_d.seen = 1'b0;
        end else begin
            if (w_q.cnt != LAST) begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
            if (!devsel_n) begin
                w_d.seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign expired = run && !w_q.seen && devsel_n && (w_q.cnt == LAST);

endmodule

// File: rtl/pcim_seq.sv
module pcim_seq
    import pcim_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned STEP_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              loc_req,
    input  logic              loc_we,
    input  logic              loc_word,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [BUS_W-1:0]  loc_wdata,
    input  logic              gnt_n,
    input  logic              devsel_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic [BE_W-1:0]   be_n,
    input  logic [BUS_W-1:0]  lane_wdata,
    input  logic [BUS_W-1:0]  rd_value,
    input  logic              expired,
    output logic [ADDR_W-1:0] held_addr,
    output logic              held_word,
    output logic [BUS_W-1:0]  held_wdata,
    output logic              data_run,
    output logic              loc_ack,
    output logic              loc_err,
    output logic              loc_retry,
    output logic [BUS_W-1:0]  loc_rdata,
    output logic              req_n,
    output logic              frame_n,
    output logic              irdy_n,
    output logic [BUS_W-1:0]  ad_o,
    output logic              ad_oe,
    output logic [BE_W-1:0]   cbe_n_o,
    output logic              cbe_oe
);
    localparam int unsigned STEP_W = $clog2(STEP_CLKS + 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CLKS - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] cnt;
        logic              cfg;
        logic              we;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
        logic              req_n;
        logic              frame_n;
        logic              irdy_n;
        logic              ad_oe;
        logic [BUS_W-1:0]  ad;
        logic              cbe_oe;
        logic [BE_W-1:0]   cbe;
        logic              ack;
        logic              err;
        logic              retry;
        logic [BUS_W-1:0]  rdata;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:      ST_IDLE,
        cnt:     '0,
        cfg:     1'b0,
        we:      1'b0,
        word:    1'b0,
        addr:    '0,
        wdata:   '0,
        req_n:   1'b1,
        frame_n: 1'b1,
        irdy_n:  1'b1,
        ad_oe:   1'b0,
        ad:      '0,
        cbe_oe:  1'b0,
        cbe:     '1,
        ack:     1'b0,
        err:     1'b0,
        retry:   1'b0,
        rdata:   '0
    };

    seq_t s_d, s_q;
    logic [3:0] cmd;
    logic       finish;

    always_comb begin
        if (s_q.cfg) begin
            cmd = s_q.we ? CMD_CFG_WR : CMD_CFG_RD;
        end else begin
            cmd = s_q.we ? CMD_MEM_WR : CMD_MEM_RD;
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.ack   = 1'b0;
        s_d.err   = 1'b0;
        s_d.retry = 1'b0;
        finish    = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (loc_req) begin
                    s_d.cfg   = cfg_mode;
                    s_d.we    = loc_we;
                    s_d.word  = loc_word;
                    s_d.addr  = loc_addr;
                    s_d.wdata = loc_wdata;
                    s_d.req_n = 1'b0;
                    s_d.st    = ST_REQ;
                end
            end
            ST_REQ: begin
                if (!gnt_n) begin
                    s_d.req_n = 1'b1;
                    s_d.ad_oe = 1'b1;
                    s_d.ad    = bus_addr;
                    s_d.cnt   = '0;
                    s_d.st    = ST_STEP;
                end
            end
            ST_STEP: begin
                if (s_q.cnt == STEP_LAST) begin
                    s_d.frame_n = 1'b0;
                    s_d.cbe_oe  = 1'b1;
                    s_d.cbe     = cmd;
                    s_d.st      = ST_FRAME;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_FRAME: begin
                s_d.frame_n = 1'b1;
                s_d.irdy_n  = 1'b0;
                s_d.cbe     = be_n;
                if (s_q.we) begin
                    s_d.ad = lane_wdata;
                end else begin
                    s_d.ad_oe = 1'b0;
                end
                s_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (!devsel_n && !trdy_n) begin
                    finish    = 1'b1;
                    s_d.rdata = s_q.we ? '0 : rd_value;
                end else if (!stop_n) begin
                    finish    = 1'b1;
                    s_d.retry = 1'b1;
                    s_d.rdata = '0;
                end else if (expired) begin
                    finish    = 1'b1;
                    s_d.err   = 1'b1;
                    s_d.rdata = '1;
                end
                if (finish) begin
                    s_d.ack    = 1'b1;
                    s_d.irdy_n = 1'b1;
                    s_d.ad_oe  = 1'b0;
                    s_d.cbe_oe = 1'b0;
                    s_d.cbe    = '1;
                    s_d.st     = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign held_addr  = s_q.addr;
    assign held_word  = s_q.word;
    assign held_wdata = s_q.wdata;
    assign data_run   = (s_q.st == ST_DATA);
    assign loc_ack    = s_q.ack;
    assign loc_err    = s_q.err;
    assign loc_retry  = s_q.retry;
    assign loc_rdata  = s_q.rdata;
    assign req_n      = s_q.req_n;
    assign frame_n    = s_q.frame_n;
    assign irdy_n     = s_q.irdy_n;
    assign ad_o       = s_q.ad;
    assign ad_oe      = s_q.ad_oe;
    assign cbe_n_o    = s_q.cbe;
    assign cbe_oe     = s_q.cbe_oe;

endmodule

// File: rtl/pci_cfg_initiator.sv
module pci_cfg_initiator
    import pcim_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned STEP_CLKS   = 4,
    parameter int unsigned DEVSEL_WAIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              loc_req,
    input  logic              loc_we,
    input  logic              loc_word,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [31:0]       loc_wdata,
    output logic              loc_ack,
    output logic              loc_err,
    output logic              loc_retry,
    output logic [31:0]       loc_rdata,
    output logic              req_n,
    input  logic              gnt_n,
    output logic              frame_n,
    output logic              irdy_n,
    input  logic              devsel_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    output logic [31:0]       ad_o,
    output logic              ad_oe,
    input  logic [31:0]       ad_i,
    output logic [3:0]        cbe_n_o,
    output logic              cbe_oe
);
    logic [ADDR_W-1:0] held_addr;
    logic              held_word;
    logic [BUS_W-1:0]  held_wdata;
    logic [BUS_W-1:0]  bus_addr;
    logic [BE_W-1:0]   be_n;
    logic [BUS_W-1:0]  lane_wdata;
    logic [BUS_W-1:0]  rd_value;
    logic              data_run;
    logic              expired;

    pcim_lane #(.ADDR_W(ADDR_W)) lane_i (
        .addr       (held_addr),
        .word       (held_word),
        .wdata      (held_wdata),
        .ad_in      (ad_i),
        .bus_addr   (bus_addr),
        .be_n       (be_n),
        .lane_wdata (lane_wdata),
        .rd_value   (rd_value)
    );

    pcim_wait #(.DEVSEL_WAIT(DEVSEL_WAIT)) wait_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (data_run),
        .devsel_n (devsel_n),
        .expired  (expired)
    );

    pcim_seq #(.ADDR_W(ADDR_W), .STEP_CLKS(STEP_CLKS)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .loc_req    (loc_req),
        .loc_we     (loc_we),
        .loc_word   (loc_word),
        .loc_addr   (loc_addr),
        .loc_wdata  (loc_wdata),
        .gnt_n      (gnt_n),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n),
        .bus_addr   (bus_addr),
        .be_n       (be_n),
        .lane_wdata (lane_wdata),
        .rd_value   (rd_value),
        .expired    (expired),
        .held_addr  (held_addr),
        .held_word  (held_word),
        .held_wdata (held_wdata),
        .data_run   (data_run),
        .loc_ack    (loc_ack),
        .loc_err    (loc_err),
        .loc_retry  (loc_retry),
        .loc_rdata  (loc_rdata),
        .req_n      (req_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe),
        .cbe_n_o    (cbe_n_o),
        .cbe_oe     (cbe_oe)
    );

endmodule

// File: rtl/pci_cfg_initiator_chk.sv
module pci_cfg_initiator_chk #(
    parameter int unsigned STEP_CLKS = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        gnt_n,
    input logic        req_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic        ad_oe,
    input logic        cbe_oe,
    input logic [3:0]  cbe_n_o,
    input logic        loc_ack,
    input logic        loc_err,
    input logic        loc_retry,
    input logic [31:0] loc_rdata
);
    logic [7:0] step_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
        end else if (ad_oe && frame_n && irdy_n) begin
            if (step_cnt != 8'hFF) begin
                step_cnt <= step_cnt + 8'd1;
            end
        end else begin
            step_cnt <= '0;
        end
    end

    AST_AD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> ($past(!gnt_n) && req_n)) else $error("ad before grant"); // R1

    AST_STEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> (step_cnt == 8'(STEP_CLKS))) else $error("step length"); // R2

    AST_CMD_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> (cbe_oe && ad_oe && (cbe_n_o == 4'hA || cbe_n_o == 4'hB ||
                      cbe_n_o == 4'h6 || cbe_n_o == 4'h7))) else $error("command"); // R3

    AST_IRDY_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (frame_n && !irdy_n)) else $error("irdy order"); // R4

    AST_ACK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |-> $past(!irdy_n)) else $error("ack without data phase"); // R5

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_err || loc_retry) |-> (loc_ack && !(loc_err && loc_retry))) else $error("outcome"); // R6

    AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ack && loc_err) |-> (loc_rdata == 32'hFFFF_FFFF)) else $error("abort data"); // R7

    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |-> (irdy_n && frame_n && !ad_oe && !cbe_oe)) else $error("release"); // R8

endmodule

bind pci_cfg_initiator pci_cfg_initiator_chk #(.STEP_CLKS(STEP_CLKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_n     (gnt_n),
    .req_n     (req_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .ad_oe     (ad_oe),
    .cbe_oe    (cbe_oe),
    .cbe_n_o   (cbe_n_o),
    .loc_ack   (loc_ack),
    .loc_err   (loc_err),
    .loc_retry (loc_retry),
    .loc_rdata (loc_rdata)
);

// File: tb/pci_cfg_initiator_tb_top.sv
module pci_cfg_initiator_tb_top;
    localparam int CLK_P       = 10;
    localparam int STEP        = 4;
    localparam int DWAIT       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0;
    logic        loc_req = 1'b0;
    logic        loc_we = 1'b0;
    logic        loc_word = 1'b0;
    logic [15:0] loc_addr = '0;
    logic [31:0] loc_wdata = '0;
    logic        loc_ack, loc_err, loc_retry;
    logic [31:0] loc_rdata;
    logic        req_n, frame_n, irdy_n, ad_oe, cbe_oe;
    logic        gnt_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic [31:0] ad_o;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_n_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct packed {
        logic        err;
        logic        retry;
        logic        rd;
        logic [31:0] rdata;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    pci_cfg_initiator #(.ADDR_W(16), .STEP_CLKS(STEP), .DEVSEL_WAIT(DWAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .loc_req(loc_req),
        .loc_we(loc_we), .loc_word(loc_word), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_ack(loc_ack), .loc_err(loc_err), .loc_retry(loc_retry), .loc_rdata(loc_rdata),
        .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .cbe_n_o(cbe_n_o), .cbe_oe(cbe_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // kind: 0 normal completion, 1 target stop, 2 no claim
    task automatic xfer(input bit cfg, input bit flip, input bit we, input bit word,
                        input logic [15:0] addr, input logic [31:0] wd, input int kind,
                        input int w, input int gd, input logic [31:0] rv);
        logic        hs;
        logic [3:0]  e_be, e_cmd;
        logic [31:0] e_wd, e_addr, e_rd;
        exp_t        item;
        int          n;
        hs     = ~addr[1];
        e_addr = {16'h0, addr[15:2], 2'b00};
        e_be   = word ? 4'b0000 : (hs ? 4'b0011 : 4'b1100);
        e_wd   = word ? wd : (hs ? {wd[15:0], 16'h0} : {16'h0, wd[15:0]});
        e_rd   = word ? rv : {16'h0, (hs ? rv[31:16] : rv[15:0])};
        e_cmd  = cfg ? (we ? 4'hB : 4'hA) : (we ? 4'h7 : 4'h6);
        item.rd    = !we;
        item.err   = (kind == 2);
        item.retry = (kind == 1);
        item.rdata = (kind == 2) ? 32'hFFFF_FFFF : ((kind == 0 && !we) ? e_rd : 32'h0);
        sb_q.push_back(item);

        cfg_mode = cfg; loc_we = we; loc_word = word; loc_addr = addr; loc_wdata = wd;
        loc_req = 1'b1;
        @(negedge clk);
        if (flip) cfg_mode = ~cfg;
        chk(req_n == 1'b0 && !ad_oe && !cbe_oe && frame_n && irdy_n, "R1 request", {31'h0, req_n}, 32'h0);
        for (int i = 0; i < gd; i++) begin
            @(negedge clk);
            chk(!ad_oe && req_n == 1'b0 && frame_n, "R1 wait grant", {31'h0, ad_oe}, 32'h0);
        end
        gnt_n = 1'b0;
        @(negedge clk);
        gnt_n = 1'b1;
        chk(ad_oe && req_n, "R1 grant", {30'h0, ad_oe, req_n}, 32'h3);
        chk(ad_o == e_addr, "R9 address", ad_o, e_addr);
        n = 1;
        while (frame_n && n < 20) begin
            @(negedge clk);
            if (frame_n) n++;
        end
        chk(n == STEP, "R2 stepping", n, STEP);
        chk(ad_o == e_addr && ad_oe, "R2 address held", ad_o, e_addr);
        chk(cbe_oe && cbe_n_o == e_cmd, "R3 command", {28'h0, cbe_n_o}, {28'h0, e_cmd});
        @(negedge clk);
        chk(!irdy_n && frame_n, "R4 irdy", {30'h0, irdy_n, frame_n}, 32'h1);
        chk(cbe_n_o == e_be, word ? "R10 byte enables" : "R9 byte enables", {28'h0, cbe_n_o}, {28'h0, e_be});
        if (we) chk(ad_oe && ad_o == e_wd, word ? "R10 write lanes" : "R9 write lanes", ad_o, e_wd);
        else    chk(!ad_oe, "R4 read turnaround", {31'h0, ad_oe}, 32'h0);
        if (kind == 0) begin
            devsel_n = 1'b0;
            for (int i = 0; i < w; i++) begin
                @(negedge clk);
                chk(!loc_ack && !irdy_n, "R5 wait state", {31'h0, loc_ack}, 32'h0);
            end
            trdy_n = 1'b0;
            ad_i   = rv;
            @(negedge clk);
            devsel_n = 1'b1; trdy_n = 1'b1; ad_i = '0;
        end else if (kind == 1) begin
            devsel_n = 1'b0; stop_n = 1'b0;
            @(negedge clk);
            devsel_n = 1'b1; stop_n = 1'b1;
        end else begin
            for (int i = 0; i < DWAIT - 1; i++) begin
                @(negedge clk);
                chk(!loc_ack, "R7 early abort", {31'h0, loc_ack}, 32'h0);
            end
            @(negedge clk);
        end
        chk(loc_ack == 1'b1, "R5 ack", {31'h0, loc_ack}, 32'h1);
        chk(irdy_n && frame_n && !ad_oe && !cbe_oe, "R8 release",
            {28'h0, irdy_n, frame_n, ad_oe, cbe_oe}, 32'hC);
        loc_req = 1'b0;
        @(negedge clk);
        chk(!loc_ack, "R5 ack one cycle", {31'h0, loc_ack}, 32'h0);
        if (kind == 1) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(req_n && !ad_oe, "R6 no reissue", {31'h0, req_n}, 32'h1);
            end
        end
    endtask

    // monitor: compares completions with the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && loc_ack) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected ack", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(loc_err == e.err, "R7 error flag", {31'h0, loc_err}, {31'h0, e.err});
                    chk(loc_retry == e.retry, "R6 retry flag", {31'h0, loc_retry}, {31'h0, e.retry});
                    if (e.rd || e.err)
                        chk(loc_rdata == e.rdata, "R5 read data", loc_rdata, e.rdata);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        chk(1'b0, "R5 watchdog", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_n && frame_n && irdy_n && !ad_oe && !cbe_oe && !loc_ack, "R1 reset state",
            {26'h0, req_n, frame_n, irdy_n, ad_oe, cbe_oe, loc_ack}, 32'h38);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // cfg halfword write at local 6 -> lanes 0-1
        xfer(1'b1, 1'b0, 1'b1, 1'b0, 16'h0006, 32'h0000_0147, 0, 0, 0, 32'h0);
        // cfg halfword read at local 4 -> lanes 2-3
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 16'h0004, 32'h0, 0, 2, 1, 32'hABCD_1234);
        // cfg halfword read at local 6 -> lanes 0-1
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 16'h0846, 32'h0, 0, 0, 3, 32'h5566_7788);
        // memory word write and read
        xfer(1'b0, 1'b0, 1'b1, 1'b1, 16'h1230, 32'hDEAD_BEEF, 0, 1, 2, 32'h0);
        xfer(1'b0, 1'b0, 1'b0, 1'b1, 16'h0040, 32'h0, 0, 3, 0, 32'h1234_5678);
        // mode changes after acceptance: latched mode used (R3)
        xfer(1'b1, 1'b1, 1'b0, 1'b1, 16'h0100, 32'h0, 0, 0, 0, 32'h0BAD_F00D);
        xfer(1'b0, 1'b1, 1'b1, 1'b0, 16'h0012, 32'hFFFF_A5A5, 0, 0, 1, 32'h0);
        // target stop
        xfer(1'b1, 1'b0, 1'b1, 1'b1, 16'h0010, 32'h0102_0304, 1, 0, 0, 32'h0);
        // no target claim, read and write
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 16'h0002, 32'h0, 2, 0, 1, 32'h0);
        xfer(1'b0, 1'b0, 1'b1, 1'b1, 16'h2000, 32'hCAFE_0001, 2, 0, 0, 32'h0);
        // normal read after abort still completes cleanly
        xfer(1'b1, 1'b0, 1'b0, 1'b1, 16'h0008, 32'h0, 0, 4, 0, 32'h0C0F_FEE0);
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R5 all completions seen", sb_q.size(), 32'h0);
        finish_run();
    end

endmodule